// File: doc/BRIEF.md
# Three-Channel Audio Interrupt Status Collector

This block gathers the end-of-buffer interrupts of a sound controller's three DMA channels (two playback converters, DAC1 and DAC2, and one capture converter, ADC) into a single 32-bit status word and one level-sensitive interrupt line. Each channel reports a single-cycle completion pulse. That pulse latches a pending bit only while the channel's interrupt enable, taken from the serial control register, is set. Software clears a pending bit by writing the serial control register with the matching enable turned off. There is no write-one-to-clear path.

Each channel is tracked by its own three-state machine. `CH_OFF` means the enable is clear and nothing is pending. `CH_ARMED` means the enable is set and nothing is pending. `CH_PENDING` means the enable is set and a completion has been latched. The transitions are as follows:

- ENABLE: a write with the enable set moves `CH_OFF` to `CH_ARMED`.
- FIRE: a completion pulse moves `CH_ARMED` to `CH_PENDING`.
- DISARM: a write with the enable clear moves `CH_ARMED` to `CH_OFF`.
- ACK: a write with the enable clear moves `CH_PENDING` to `CH_OFF`.
- Every other case holds the current state.

A status assembler turns the three pending bits into the status word. It adds the summary bit and the fixed capture/compare source fields, and it registers the interrupt output.

Top module: `audio_irq_status`

## Requirements
- R1: After reset the status word is 0x00000060, `irq` is 0 and all three enables are clear.
- R2: Status bit 2 is the DAC1 pending bit, bit 1 is the DAC2 pending bit and bit 0 is the ADC pending bit. On `chan_done`, bit 0 is DAC1, bit 1 is DAC2 and bit 2 is ADC. On `en_wdata`, bit 0 is the DAC1 enable (serial control bit 8), bit 1 is the DAC2 enable (bit 9) and bit 2 is the ADC enable (bit 10).
- R3: A completion pulse sets its channel's pending bit only if that channel's enable held before the current cycle is 1. A pulse with that enable at 0 has no effect, including when the same cycle's write turns the enable on.
- R4: Status bit 31 equals the OR of the three pending bits in the same cycle.
- R5: `irq` is registered and equals the value of status bit 31 from the previous clock.
- R6: A write that takes an enable from 1 to 0 clears that channel's pending bit after the edge. A write that sets an enable, or that keeps it at 1, leaves the pending bit unchanged.
- R7: If a completion pulse and an enable-clearing write hit the same channel in the same cycle, the channel ends with its pending bit clear.
- R8: Status bits 6:5 always read 2'b11, bit 4 always reads 0, and bits 30:7 and 3 always read 0.
- R9: A pending bit stays set through further completion pulses and idle cycles until a write clears its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_done | input | 3 | One-cycle completion pulses (bit 0 DAC1, bit 1 DAC2, bit 2 ADC) |
| en_wr | input | 1 | Serial control write touching the enable byte |
| en_wdata | input | 3 | Enable field being written (bit 0 DAC1, bit 1 DAC2, bit 2 ADC) |
| status_word | output | 32 | Interrupt status word |
| irq | output | 1 | Level interrupt request, registered |

## Verification
The assertions assume that `chan_done`, `en_wr` and `en_wdata` are known (non-X) on every clock edge after reset. They place no restriction on which pulses and writes can coincide. The stimulus respects this by driving every input to a defined value at each falling clock edge and holding it through the next rising edge. It also deliberately overlaps pulses and writes on the same channel, and on different channels, to reach the clear-wins and enable-turn-on corners.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;

    localparam int STAT_W  = 32;
    localparam int NUM_CH  = 3;
    localparam int SRC_LO  = 5;
    localparam int SRC_W   = 2;
    localparam int CCB_BIT = 4;
    localparam logic [SRC_W-1:0] SRC_RESET = 2'b11;

    typedef enum logic [1:0] {
        CH_OFF     = 2'd0,
        CH_ARMED   = 2'd1,
        CH_PENDING = 2'd2
    } ch_state_e;

endpackage

// File: rtl/audio_irq_chan.sv
module audio_irq_chan
    import audio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic wr_i,
    input  logic en_bit_i,
    output logic pending_o
);

    ch_state_e state_q;
    ch_state_e state_d;

    // Next-state logic: the enable-clearing write is tested first, so it wins over a pulse.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (wr_i && en_bit_i) begin
                    state_d = CH_ARMED;          // ENABLE
                end
            end
            CH_ARMED: begin
                if (wr_i && !en_bit_i) begin
                    state_d = CH_OFF;            // DISARM
                end else if (done_i) begin
                    state_d = CH_PENDING;        // FIRE
                end
            end
            CH_PENDING: begin
                if (wr_i && !en_bit_i) begin
                    state_d = CH_OFF;            // ACK
                end
            end
            default: state_d = CH_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        pending_o = (state_q == CH_PENDING);
    end

    assert_set_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OFF) |=> !pending_o);

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !en_bit_i) |=> !pending_o);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !(wr_i && !en_bit_i)) |=> pending_o);

    assert_enable_on_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending_o && wr_i && en_bit_i && state_q != CH_ARMED) |=> !pending_o);

endmodule

// File: rtl/audio_irq_status_pack.sv
module audio_irq_status_pack
    import audio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pend_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);

    logic any_pend;

    always_comb begin
        any_pend = |pend_i;
        status_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            status_o[NUM_CH-1-i] = pend_i[i];
        end
        status_o[SRC_LO +: SRC_W] = SRC_RESET;
        status_o[CCB_BIT]         = 1'b0;
        status_o[STAT_W-1]        = any_pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= any_pend;
        end
    end

    assert_irq_lags_summary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(status_o[STAT_W-1])));

    assert_fixed_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[STAT_W-2:0] & ~{{(STAT_W-NUM_CH-1){1'b0}}, {NUM_CH{1'b1}}}) == 31'h60);

    assert_summary_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[STAT_W-1] == (|status_o[NUM_CH-1:0]));

endmodule

// File: rtl/audio_irq_status.sv
module audio_irq_status
    import audio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        chan_done,
    input  logic              en_wr,
    input  logic [2:0]        en_wdata,
    output logic [31:0]       status_word,
    output logic              irq
);

    logic [NUM_CH-1:0] pend;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        audio_irq_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .done_i    (chan_done[g]),
            .wr_i      (en_wr),
            .en_bit_i  (en_wdata[g]),
            .pending_o (pend[g])
        );
    end

    audio_irq_status_pack u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend),
        .status_o (status_word),
        .irq_o    (irq)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (status_word == 32'h0000_0060 && !irq));

endmodule

// File: tb/audio_irq_status_tb.sv
module audio_irq_status_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  chan_done = '0;
    logic        en_wr = 1'b0;
    logic [2:0]  en_wdata = '0;
    logic [31:0] status_word;
    logic        irq;

    always #4 clk = ~clk;

    audio_irq_status u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_done   (chan_done),
        .en_wr       (en_wr),
        .en_wdata    (en_wdata),
        .status_word (status_word),
        .irq         (irq)
    );

    typedef struct {
        logic [31:0] st;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done_flag = 0;

    logic [2:0] m_en   = '0;
    logic [2:0] m_pend = '0;

    function automatic logic [31:0] mk_status(logic [2:0] p);
        logic [31:0] w;
        w = 32'h0000_0060;
        w[2] = p[0];
        w[1] = p[1];
        w[0] = p[2];
        w[31] = |p;
        return w;
    endfunction

    task automatic drive(input logic [2:0] ev, input logic wr, input logic [2:0] en, input string tag);
        exp_t e;
        logic old_sum;
        @(negedge clk);
        chan_done = ev;
        en_wr     = wr;
        en_wdata  = en;
        old_sum   = |m_pend;
        for (int i = 0; i < 3; i++) begin
            if (wr && !en[i]) m_pend[i] = 1'b0;
            else if (ev[i] && m_en[i]) m_pend[i] = 1'b1;
        end
        if (wr) m_en = en;
        @(posedge clk);
        e.st  = mk_status(m_pend);
        e.irq = old_sum;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (status_word !== e.st || irq !== e.irq) begin
                fails++;
                $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                         e.tag, status_word, irq, e.st, e.irq);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (status_word !== 32'h0000_0060 || irq !== 1'b0) begin
            fails++;
            $display("FAIL R1: status=%h irq=%b expected status=00000060 irq=0", status_word, irq);
        end
        rst_n = 1'b1;
        drive(3'b111, 1'b0, 3'b000, "R3 pulses while disabled");
        drive(3'b000, 1'b1, 3'b001, "R6 enable DAC1 no set");
        drive(3'b001, 1'b0, 3'b000, "R2 R4 DAC1 fires");
        drive(3'b000, 1'b0, 3'b000, "R5 irq follows");
        drive(3'b100, 1'b0, 3'b000, "R3 ADC disabled pulse");
        drive(3'b000, 1'b1, 3'b111, "R6 enable all keeps pending");
        drive(3'b110, 1'b0, 3'b000, "R2 DAC2 and ADC fire");
        drive(3'b000, 1'b1, 3'b101, "R6 clear DAC2");
        drive(3'b100, 1'b1, 3'b001, "R7 clear wins on ADC");
        drive(3'b001, 1'b0, 3'b000, "R9 repeat pulse sticky");
        drive(3'b000, 1'b0, 3'b000, "R9 idle sticky");
        drive(3'b000, 1'b1, 3'b000, "R6 clear all");
        drive(3'b000, 1'b0, 3'b000, "R5 irq drops");
        drive(3'b100, 1'b1, 3'b100, "R3 enable same cycle no set");
        drive(3'b100, 1'b0, 3'b000, "R2 ADC fires");
        drive(3'b000, 1'b0, 3'b000, "R8 fixed fields");
        drive(3'b000, 1'b0, 3'b000, "R5 settle");
        @(negedge clk);
        @(negedge clk);
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule